// File: doc/BRIEF.md
# Ring Node Transfer Sequencer

This block is the control sequencer for one node on a unidirectional ring. It decides, one transfer at a time, among three jobs. The first is injecting a word from the local processor onto the outgoing link. The second is delivering a word that arrived on the incoming link to the local processor. The third is forwarding such a word on to the next node. The data latches sit outside the block. The sequencer only produces their capture and output-enable strobes, together with the request and acknowledge lines of the three handshakes.

Every handshake is four-phase, whether it is the processor write, the processor read, the upstream link or the downstream link. A request is raised and held until it is acknowledged. The acknowledge is then held until the request falls. Back-pressure works through this rule alone. The sequencer holds a downstream request for as long as the next node withholds its acknowledge. It keeps an acknowledge up for as long as the requester keeps its request. No new transfer starts until the running one has fully closed.

All strobes come from flip-flops and depend only on the sequencer state. An input edge can therefore never glitch a latch clock. An idle controller with several requests pending serves the incoming link first, so ring traffic is never held behind local injection.

Top module: `rr_hs_ctrl`

## Requirements
- R1: While `rst_n` is low, every output is 0 and the sequencer is idle, whatever state it was in before. The low level takes effect without waiting for a clock edge.
- R2: In idle, a sampled `in_req` wins over `wr_req`. With `in_req` high, `in_local`=1 selects delivery and `in_local`=0 selects forwarding. With `in_req` low and `wr_req` high, injection starts. `rd_req` alone does not start anything. When no request starts a transfer, all outputs stay 0.
- R3: Injection begins with `wr_buf_clk` high for exactly one cycle. The next cycle raises `wr_buf_en` and `out_req`, and both are held while `out_ack` is low.
- R4: When `out_ack` is sampled high during injection, all outputs go to 0 until `out_ack` is sampled low. `wr_ack` is then raised and held while `wr_req` stays high. After `wr_req` is sampled low, the sequencer returns to idle.
- R5: Delivery begins with `in_buf_clk` high for one cycle. `in_ack` follows and is held while `in_req` stays high.
- R6: After `in_req` falls during delivery, outputs are 0 until `rd_req` is sampled high. Then `in_buf_en`, `rd_buf_en` and `rd_ack` are raised together and held while `rd_req` stays high. After `rd_req` is sampled low, the sequencer returns to idle.
- R7: Forwarding begins with `in_buf_clk` high for one cycle. Next, `in_buf_en` and `out_req` are held until `out_ack` is sampled high. Outputs are 0 until `out_ack` is sampled low. Then `in_ack` is held until `in_req` is sampled low, and the sequencer returns to idle.
- R8: Inputs that do not belong to the handshake currently being waited on have no effect on the outputs.
- R9: At most one transfer is active. `out_req` is always accompanied by exactly one of `wr_buf_en` and `in_buf_en`, and `rd_ack` is never high together with `out_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Processor asks to inject a word |
| rd_req | input | 1 | Processor asks for the delivered word |
| in_req | input | 1 | Upstream node offers a word |
| in_local | input | 1 | The offered word is addressed to this node |
| out_ack | input | 1 | Downstream node acknowledges `out_req` |
| rd_buf_en | output | 1 | Drive the input latch toward the processor |
| wr_buf_en | output | 1 | Output enable of the write latch onto the link |
| wr_buf_clk | output | 1 | Capture pulse for the write latch |
| in_buf_en | output | 1 | Output enable of the input latch |
| in_buf_clk | output | 1 | Capture pulse for the input latch |
| wr_ack | output | 1 | Acknowledge to the processor write |
| rd_ack | output | 1 | Acknowledge to the processor read |
| out_req | output | 1 | Request to the downstream node |
| in_ack | output | 1 | Acknowledge to the upstream node |

## Verification
The hardest situations to reach are the collisions. Two or more requests can be present in the idle cycle, and unrelated requests can toggle while the sequencer waits on a different handshake. The bench sweeps all sixteen combinations of `in_req`, `in_local`, `wr_req` and `rd_req` at idle and runs the chosen sequence to completion. During each wait it raises the requests of the other transfers as noise. Where the write lost arbitration, the bench then confirms that the pending write is served afterwards. A reset is also applied in the middle of a forward.

// File: rtl/rr_hs_pkg.sv
package rr_hs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_W_CLK  = 4'd1,
    ST_W_SEND = 4'd2,
    ST_W_DROP = 4'd3,
    ST_W_ACK  = 4'd4,
    ST_R_CLK  = 4'd5,
    ST_R_IACK = 4'd6,
    ST_R_WAIT = 4'd7,
    ST_R_GIVE = 4'd8,
    ST_P_CLK  = 4'd9,
    ST_P_SEND = 4'd10,
    ST_P_DROP = 4'd11,
    ST_P_ACK  = 4'd12
  } seq_state_t;

  typedef struct packed {
    logic rd_buf_en;
    logic wr_buf_en;
    logic wr_buf_clk;
    logic in_buf_en;
    logic in_buf_clk;
    logic wr_ack;
    logic rd_ack;
    logic out_req;
    logic in_ack;
  } strobe_t;

  localparam int STROBE_W = $bits(strobe_t);

endpackage

// File: rtl/rr_hs_next.sv
module rr_hs_next
  import rr_hs_pkg::*;
(
  input  seq_state_t cur,
  input  logic       wr_req,
  input  logic       rd_req,
  input  logic       in_req,
  input  logic       in_local,
  input  logic       out_ack,
  output seq_state_t nxt
);

  always_comb begin
    nxt = cur;
    unique case (cur)
      ST_IDLE: begin
        if (in_req)      nxt = in_local ? ST_R_CLK : ST_P_CLK;
        else if (wr_req) nxt = ST_W_CLK;
      end
      ST_W_CLK:  nxt = ST_W_SEND;
      ST_W_SEND: if (out_ack)  nxt = ST_W_DROP;
      ST_W_DROP: if (!out_ack) nxt = ST_W_ACK;
      ST_W_ACK:  if (!wr_req)  nxt = ST_IDLE;
      ST_R_CLK:  nxt = ST_R_IACK;
      ST_R_IACK: if (!in_req)  nxt = ST_R_WAIT;
      ST_R_WAIT: if (rd_req)   nxt = ST_R_GIVE;
      ST_R_GIVE: if (!rd_req)  nxt = ST_IDLE;
      ST_P_CLK:  nxt = ST_P_SEND;
      ST_P_SEND: if (out_ack)  nxt = ST_P_DROP;
      ST_P_DROP: if (!out_ack) nxt = ST_P_ACK;
      ST_P_ACK:  if (!in_req)  nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/rr_hs_decode.sv
module rr_hs_decode
  import rr_hs_pkg::*;
(
  input  seq_state_t st,
  output strobe_t    strb
);

  always_comb begin
    strb = '0;
    unique case (st)
      ST_W_CLK:  strb.wr_buf_clk = 1'b1;
      ST_W_SEND: begin
        strb.wr_buf_en = 1'b1;
        strb.out_req   = 1'b1;
      end
      ST_W_ACK:  strb.wr_ack = 1'b1;
      ST_R_CLK:  strb.in_buf_clk = 1'b1;
      ST_R_IACK: strb.in_ack = 1'b1;
      ST_R_GIVE: begin
        strb.in_buf_en = 1'b1;
        strb.rd_buf_en = 1'b1;
        strb.rd_ack    = 1'b1;
      end
      ST_P_CLK:  strb.in_buf_clk = 1'b1;
      ST_P_SEND: begin
        strb.in_buf_en = 1'b1;
        strb.out_req   = 1'b1;
      end
      ST_P_ACK:  strb.in_ack = 1'b1;
      default:   strb = '0;
    endcase
  end

endmodule

// File: rtl/rr_hs_ctrl.sv
module rr_hs_ctrl
  import rr_hs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_req,
  input  logic rd_req,
  input  logic in_req,
  input  logic in_local,
  input  logic out_ack,
  output logic rd_buf_en,
  output logic wr_buf_en,
  output logic wr_buf_clk,
  output logic in_buf_en,
  output logic in_buf_clk,
  output logic wr_ack,
  output logic rd_ack,
  output logic out_req,
  output logic in_ack
);

  seq_state_t state_q, state_d;
  strobe_t    strb_d, strb_q;

  rr_hs_next u_next (
    .cur      (state_q),
    .wr_req   (wr_req),
    .rd_req   (rd_req),
    .in_req   (in_req),
    .in_local (in_local),
    .out_ack  (out_ack),
    .nxt      (state_d)
  );

  // Decode the next state so that the strobes are flip-flop outputs.
  rr_hs_decode u_dec (
    .st   (state_d),
    .strb (strb_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      strb_q  <= '0;
    end else begin
      state_q <= state_d;
      strb_q  <= strb_d;
    end
  end

  assign rd_buf_en  = strb_q.rd_buf_en;
  assign wr_buf_en  = strb_q.wr_buf_en;
  assign wr_buf_clk = strb_q.wr_buf_clk;
  assign in_buf_en  = strb_q.in_buf_en;
  assign in_buf_clk = strb_q.in_buf_clk;
  assign wr_ack     = strb_q.wr_ack;
  assign rd_ack     = strb_q.rd_ack;
  assign out_req    = strb_q.out_req;
  assign in_ack     = strb_q.in_ack;

  // R3
  wr_clk_then_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_buf_clk |=> (wr_buf_en && out_req && !wr_buf_clk));

  // R5
  in_clk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_buf_clk |=> (!in_buf_clk && (in_ack || (in_buf_en && out_req))));

  // R4
  out_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && !out_ack) |=> out_req);

  // R7
  in_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ack && in_req) |=> in_ack);

  // R4
  wr_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && wr_req) |=> wr_ack);

  // R6
  rd_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && rd_req) |=> (rd_ack && rd_buf_en && in_buf_en));

  // R9
  single_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_req |-> $onehot({wr_buf_en, in_buf_en}));

  // R9
  no_mixed_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_ack && out_req));

endmodule

// File: tb/tb_rr_hs_ctrl.sv
module tb_rr_hs_ctrl;

  localparam int CLK_PERIOD = 10;

  localparam logic [8:0] O_RBE  = 9'b1_0000_0000;
  localparam logic [8:0] O_WBE  = 9'b0_1000_0000;
  localparam logic [8:0] O_WCLK = 9'b0_0100_0000;
  localparam logic [8:0] O_IBE  = 9'b0_0010_0000;
  localparam logic [8:0] O_ICLK = 9'b0_0001_0000;
  localparam logic [8:0] O_WACK = 9'b0_0000_1000;
  localparam logic [8:0] O_RACK = 9'b0_0000_0100;
  localparam logic [8:0] O_OREQ = 9'b0_0000_0010;
  localparam logic [8:0] O_IACK = 9'b0_0000_0001;

  logic clk = 1'b0;
  logic rst_n, wr_req, rd_req, in_req, in_local, out_ack;
  logic rd_buf_en, wr_buf_en, wr_buf_clk, in_buf_en, in_buf_clk;
  logic wr_ack, rd_ack, out_req, in_ack;
  int   n_chk = 0;
  int   n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rr_hs_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
    .in_req(in_req), .in_local(in_local), .out_ack(out_ack),
    .rd_buf_en(rd_buf_en), .wr_buf_en(wr_buf_en), .wr_buf_clk(wr_buf_clk),
    .in_buf_en(in_buf_en), .in_buf_clk(in_buf_clk), .wr_ack(wr_ack),
    .rd_ack(rd_ack), .out_req(out_req), .in_ack(in_ack)
  );

  wire [8:0] obs = {rd_buf_en, wr_buf_en, wr_buf_clk, in_buf_en, in_buf_clk,
                    wr_ack, rd_ack, out_req, in_ack};

  task automatic chk(input string req, input logic [8:0] exp);
    n_chk++;
    if (obs !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, obs, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Injection, entered with wr_buf_clk already observed.
  task automatic finish_write(input logic noise);
    out_ack = 1'b0; in_req = noise; rd_req = noise;
    tick(); chk("R3 send", O_WBE | O_OREQ);
    tick(); chk("R8 send held under noise", O_WBE | O_OREQ);
    out_ack = 1'b1;
    tick(); chk("R4 req drop", 9'b0);
    tick(); chk("R4 wait ack low", 9'b0);
    out_ack = 1'b0;
    tick(); chk("R4 wr_ack", O_WACK);
    tick(); chk("R4 wr_ack held", O_WACK);
    in_req = 1'b0; rd_req = 1'b0; wr_req = 1'b0;
    tick(); chk("R4 back to idle", 9'b0);
  endtask

  task automatic finish_read(input logic noise);
    wr_req = noise; out_ack = noise;
    tick(); chk("R5 in_ack", O_IACK);
    tick(); chk("R5 in_ack held", O_IACK);
    in_req = 1'b0; rd_req = 1'b0;
    tick(); chk("R6 wait rd_req", 9'b0);
    tick(); chk("R8 wait ignores noise", 9'b0);
    rd_req = 1'b1;
    tick(); chk("R6 deliver", O_IBE | O_RBE | O_RACK);
    tick(); chk("R6 deliver held", O_IBE | O_RBE | O_RACK);
    rd_req = 1'b0; wr_req = 1'b0; out_ack = 1'b0;
    tick(); chk("R6 back to idle", 9'b0);
  endtask

  task automatic finish_pass(input logic noise);
    out_ack = 1'b0; rd_req = noise;
    tick(); chk("R7 forward", O_IBE | O_OREQ);
    tick(); chk("R8 forward held", O_IBE | O_OREQ);
    out_ack = 1'b1;
    tick(); chk("R7 req drop", 9'b0);
    out_ack = 1'b0;
    tick(); chk("R7 in_ack", O_IACK);
    tick(); chk("R7 in_ack held", O_IACK);
    in_req = 1'b0; rd_req = 1'b0;
    tick(); chk("R7 back to idle", 9'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_req = 0; rd_req = 0; in_req = 0; in_local = 0; out_ack = 0;
    tick(); tick();
    chk("R1 reset outputs", 9'b0);
    rst_n = 1'b1;
    tick(); chk("R2 idle no request", 9'b0);

    for (int c = 0; c < 16; c++) begin
      logic ir, lc, wq, rq, wr_pending;
      ir = c[3]; lc = c[2]; wq = c[1]; rq = c[0];
      in_req = ir; in_local = lc; wr_req = wq; rd_req = rq; out_ack = 1'b0;
      tick();
      wr_pending = 1'b0;
      if (ir) begin
        chk("R2 link wins, capture input", O_ICLK);
        wr_pending = wq;
        if (lc) finish_read(wq);
        else    finish_pass(wq);
      end else if (wq) begin
        chk("R2 write starts", O_WCLK);
        finish_write(rq);
      end else begin
        chk("R2 rd_req alone ignored", 9'b0);
        rd_req = 1'b0;
        tick(); chk("R2 stays idle", 9'b0);
      end
      if (wr_pending) begin
        wr_req = 1'b1;
        tick(); chk("R2 deferred write served", O_WCLK);
        finish_write(1'b0);
      end
    end

    // Reset in the middle of a forward.
    in_req = 1'b1; in_local = 1'b0;
    tick(); chk("R7 capture", O_ICLK);
    tick(); chk("R7 forward", O_IBE | O_OREQ);
    #1 rst_n = 1'b0;
    #1 chk("R1 reset mid transfer", 9'b0);
    in_req = 1'b0;
    tick(); rst_n = 1'b1;
    tick(); chk("R1 idle after reset", 9'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule